// File: doc/BRIEF.md
# Two-Phase Microcode Sequencer

This block steps through a microprogram held in an internal ROM and turns each 16-bit microword into control strobes for a 4-bit datapath. It runs at twice the instruction clock. Every microcode step therefore takes two clock cycles. The first is a fetch half, in which the word at the current microaddress is read. The second is an execute half, in which that word drives the datapath. Program-counter loads must land before the next architectural instruction is read, so they are decoded straight from the ROM output and strobed in the fetch half. Nibble moves, ALU results, stack actions and interrupt entry are strobed in the execute half.

The top three bits of a microword pick the operation class. The classes are: plain nibble move, ALU-sourced move, PC immediate load or interrupt entry, microcode jump, call/return stack form, register-sourced PC load, and halt. Jumps can be unconditional, or conditional on the zero or carry flag with a chosen polarity. A halt freezes the sequencer, optionally with a request to stop the peripheral oscillator, until a wake input is raised. The datapath registers, the ALU and memory sit outside the block. The ROM image is a parameter, so an integrator supplies the microprogram at elaboration.

Top module: `useq_top`

## Requirements
- R1: While reset is high and right after it falls, the sequencer is not halted, the oscillator-stop output is low and every strobe is low. The first step executed after reset is the word at microaddress 0, and its first cycle is a fetch half.
- R2: Every step takes two cycles. `pc_wr` is only ever high in the fetch half. `mv_en`, `irq_entry` and nonzero `stk_op` are only ever high in the execute half. At most one of these is active in any cycle.
- R3: A word with bits 15:13 = 001 raises `mv_en` in the execute half. `mv_src` comes from bits 12:8, `mv_dst` from bits 7:3 and `mv_inc` from bits 2:0, and `alu_en` stays low.
- R4: A word with bits 15:13 = 010 and bit 12 = 0 raises `mv_en` and `alu_en`. `alu_op` comes from bits 11:8, `mv_dst` from bits 7:3, `mv_inc` from bits 2:0, and `mv_src` is 0. If bit 12 = 1, the word is a no-op.
- R5: A word with bits 15:13 = 100 and bit 12 = 0 is an unconditional jump. The next step executes the word at the microaddress in bits 9:0, whatever bits 11:10 hold.
- R6: A word with bits 15:13 = 100 and bit 12 = 1 is a conditional jump. Bit 11 selects the flag (0 = `flag_z`, 1 = `flag_c`) and bit 10 gives the required value. The flag is sampled in the execute half. On a match the jump goes to bits 9:0; otherwise the microaddress advances by one.
- R7: `pc_wr` pulses in the fetch half of a step whose word is a PC load. `pc_src` then reports the kind: 1 for bits 15:0 = 0x6000 (immediate), 2 for a call-end form (see R9), and 3 for bits 15:0 = 0xC000 (register). `pc_src` is 0 whenever `pc_wr` is low.
- R8: A word with bits 15:12 = 0111 and bits 11:0 = 0 raises `irq_entry` in its execute half.
- R9: A word with bits 15:13 = 101, bits 10:1 = 0 and bits 12:11 = 00, 01 or 10 drives `stk_op` to 1, 2 or 3 in its execute half, with `stk_bit` equal to bit 0. `stk_bit` is 0 whenever `stk_op` is 0.
- R10: A word with bits 15:13 = 111 and bits 12:1 = 0 sets `halted` from the next cycle, and `osc_stop` takes bit 0. While halted, the sequencer keeps its position and issues no strobes.
- R11: While halted, a high `wake` clears `halted` and `osc_stop` at the next clock edge. Execution then resumes with a fetch half of the word after the halt. `wake` has no effect while running.
- R12: Any word whose sub-fields match none of R3 to R10 issues no strobes and advances the microaddress by one.
- R13: The all-zero word issues no strobes and advances the microaddress by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| wake | input | 1 | Leaves the halted state |
| flag_z | input | 1 | Zero flag from the datapath |
| flag_c | input | 1 | Carry flag from the datapath |
| pc_wr | output | 1 | PC load strobe, fetch half |
| pc_src | output | 2 | PC load kind: 1 immediate, 2 call, 3 register |
| mv_en | output | 1 | Datapath nibble write strobe, execute half |
| mv_src | output | 5 | Source select |
| mv_dst | output | 5 | Destination select |
| mv_inc | output | 3 | Post-increment select |
| alu_en | output | 1 | Source is the ALU |
| alu_op | output | 4 | ALU operation code |
| irq_entry | output | 1 | Interrupt entry strobe |
| stk_op | output | 2 | Stack form: 1 call-end, 2 call-start, 3 return-end |
| stk_bit | output | 1 | Option bit of the stack form |
| halted | output | 1 | Sequencer is halted |
| osc_stop | output | 1 | Peripheral oscillator stop request |

## Verification
The microprogram is a 64-word image that covers every opcode class. It includes both defined and undefined sub-field values, all four flag/polarity combinations of the conditional jump, and both halt variants. It is stepped for hundreds of steps while the zero and carry flags and the wake input are driven from a pseudo-random sequence. Each conditional jump is therefore met both taken and not taken, which separates correct flag selection from inverted polarity or the wrong flag. The next fetch shows whether the jump landed on its target or on the next word. Because fetch-half and execute-half outputs are checked separately on every step, a strobe in the wrong half shows up at once. Undefined encodings that sit next to valid ones (a set bit 12, a stray low bit) show whether the decoder looks at the full sub-field.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UW   = 16;
    localparam int UAW  = 10;
    localparam int SELW = 5;
    localparam int INCW = 3;
    localparam int ALUW = 4;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_MOVE  = 3'd1,
        OP_ALU   = 3'd2,
        OP_SPEC  = 3'd3,
        OP_JUMP  = 3'd4,
        OP_STACK = 3'd5,
        OP_PCREG = 3'd6,
        OP_HALT  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        PCL_NONE = 2'd0,
        PCL_IMM  = 2'd1,
        PCL_CALL = 2'd2,
        PCL_REG  = 2'd3
    } pcl_e;

    typedef enum logic [1:0] {
        STK_NONE       = 2'd0,
        STK_CALL_END   = 2'd1,
        STK_CALL_START = 2'd2,
        STK_RET_END    = 2'd3
    } stk_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef struct packed {
        logic            mv;
        logic            alu;
        logic [SELW-1:0] src;
        logic [SELW-1:0] dst;
        logic [INCW-1:0] inc;
        logic [ALUW-1:0] aluop;
        logic            irq;
        stk_e            stk;
        logic            stkbit;
        logic            jmp;
        logic            jcond;
        logic            jflag;
        logic            jpol;
        logic [UAW-1:0]  jtgt;
        logic            halt;
        logic            osc;
    } dec_t;

    function automatic op_e opcode(input logic [UW-1:0] w);
        return op_e'(w[15:13]);
    endfunction

    // PC-load kind of a word; used on the fetch side, straight from the ROM.
    function automatic pcl_e pc_load_kind(input logic [UW-1:0] w);
        pcl_e k;
        k = PCL_NONE;
        case (opcode(w))
            OP_SPEC:  if (w[12:0] == 13'd0) k = PCL_IMM;
            OP_STACK: if (w[12:11] == 2'b00 && w[10:1] == 10'd0) k = PCL_CALL;
            OP_PCREG: if (w[12:0] == 13'd0) k = PCL_REG;
            default:  k = PCL_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
#(
    parameter int                    DEPTH = 64,
    parameter logic [DEPTH*UW-1:0]   IMAGE = '0
) (
    input  logic [UAW-1:0] addr,
    output logic [UW-1:0]  word
);

    always_comb begin
        word = '0;
        if (int'(addr) < DEPTH)
            word = IMAGE[int'(addr)*UW +: UW];
    end

endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
(
    input  logic [UW-1:0] word,
    output dec_t          d
);

    always_comb begin
        d = '0;
        case (opcode(word))
            OP_MOVE: begin
                d.mv  = 1'b1;
                d.src = word[12:8];
                d.dst = word[7:3];
                d.inc = word[2:0];
            end
            OP_ALU: begin
                if (!word[12]) begin
                    d.mv    = 1'b1;
                    d.alu   = 1'b1;
                    d.aluop = word[11:8];
                    d.dst   = word[7:3];
                    d.inc   = word[2:0];
                end
            end
            OP_SPEC: begin
                if (word[12] && word[11:0] == 12'd0)
                    d.irq = 1'b1;
            end
            OP_JUMP: begin
                d.jmp   = 1'b1;
                d.jcond = word[12];
                d.jflag = word[11];
                d.jpol  = word[10];
                d.jtgt  = word[9:0];
            end
            OP_STACK: begin
                if (word[10:1] == 10'd0) begin
                    case (word[12:11])
                        2'b00:   d.stk = STK_CALL_END;
                        2'b01:   d.stk = STK_CALL_START;
                        2'b10:   d.stk = STK_RET_END;
                        default: d.stk = STK_NONE;
                    endcase
                    d.stkbit = (word[12:11] != 2'b11) && word[0];
                end
            end
            OP_HALT: begin
                if (word[12:1] == 12'd0) begin
                    d.halt = 1'b1;
                    d.osc  = word[0];
                end
            end
            default: d = '0;
        endcase
    end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wake,
    input  logic           flag_z,
    input  logic           flag_c,
    input  logic [UW-1:0]  rom_word,
    input  logic           j_en,
    input  logic           j_cond,
    input  logic           j_flag,
    input  logic           j_pol,
    input  logic [UAW-1:0] j_tgt,
    input  logic           h_en,
    input  logic           h_osc,
    output logic [UAW-1:0] upc,
    output logic [UW-1:0]  ir,
    output phase_e         phase,
    output logic           halted,
    output logic           osc_stop
);

    logic           flag_sel;
    logic           taken;
    logic [UAW-1:0] upc_next;

    always_comb begin
        flag_sel = j_flag ? flag_c : flag_z;
        taken    = j_en && (!j_cond || (flag_sel == j_pol));
        upc_next = taken ? j_tgt : upc + UAW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upc      <= '0;
            ir       <= '0;
            phase    <= PH_FETCH;
            halted   <= 1'b0;
            osc_stop <= 1'b0;
        end else if (halted) begin
            if (wake) begin
                halted   <= 1'b0;
                osc_stop <= 1'b0;
            end
        end else if (phase == PH_FETCH) begin
            ir    <= rom_word;
            phase <= PH_EXEC;
        end else begin
            phase <= PH_FETCH;
            upc   <= upc_next;
            if (h_en) begin
                halted   <= 1'b1;
                osc_stop <= h_osc;
            end
        end
    end

endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int                        ROM_DEPTH = 64,
    parameter logic [ROM_DEPTH*16-1:0]   ROM_IMAGE = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wake,
    input  logic       flag_z,
    input  logic       flag_c,
    output logic       pc_wr,
    output logic [1:0] pc_src,
    output logic       mv_en,
    output logic [4:0] mv_src,
    output logic [4:0] mv_dst,
    output logic [2:0] mv_inc,
    output logic       alu_en,
    output logic [3:0] alu_op,
    output logic       irq_entry,
    output logic [1:0] stk_op,
    output logic       stk_bit,
    output logic       halted,
    output logic       osc_stop
);

    logic [UAW-1:0] upc;
    logic [UW-1:0]  rom_word;
    logic [UW-1:0]  ir;
    phase_e         phase;
    dec_t           de;
    dec_t           eo;
    pcl_e           pcl_f;
    logic           fetch_act;
    logic           exec_act;

    useq_rom #(
        .DEPTH (ROM_DEPTH),
        .IMAGE (ROM_IMAGE)
    ) u_rom (
        .addr (upc),
        .word (rom_word)
    );

    useq_decode u_dec (
        .word (ir),
        .d    (de)
    );

    useq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wake     (wake),
        .flag_z   (flag_z),
        .flag_c   (flag_c),
        .rom_word (rom_word),
        .j_en     (de.jmp),
        .j_cond   (de.jcond),
        .j_flag   (de.jflag),
        .j_pol    (de.jpol),
        .j_tgt    (de.jtgt),
        .h_en     (de.halt),
        .h_osc    (de.osc),
        .upc      (upc),
        .ir       (ir),
        .phase    (phase),
        .halted   (halted),
        .osc_stop (osc_stop)
    );

    always_comb begin
        fetch_act = !halted && (phase == PH_FETCH);
        exec_act  = !halted && (phase == PH_EXEC);
        pcl_f     = fetch_act ? pc_load_kind(rom_word) : PCL_NONE;
        eo        = exec_act ? de : '0;
    end

    assign pc_wr     = (pcl_f != PCL_NONE);
    assign pc_src    = pcl_f;
    assign mv_en     = eo.mv;
    assign mv_src    = eo.src;
    assign mv_dst    = eo.dst;
    assign mv_inc    = eo.inc;
    assign alu_en    = eo.alu;
    assign alu_op    = eo.aluop;
    assign irq_entry = eo.irq;
    assign stk_op    = eo.stk;
    assign stk_bit   = eo.stkbit;

endmodule

// File: rtl/useq_chk.sv
module useq_chk (
    input logic       clk,
    input logic       rst,
    input logic       wake,
    input logic       halted,
    input logic       osc_stop,
    input logic       pc_wr,
    input logic       mv_en,
    input logic       alu_en,
    input logic [4:0] mv_src,
    input logic       irq_entry,
    input logic [1:0] stk_op,
    input logic       stk_bit
);

    AST_PCWR_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        pc_wr |=> !pc_wr); // R2
    AST_MV_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        mv_en |=> !mv_en); // R2
    AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pc_wr, mv_en, irq_entry, stk_op != 2'd0})); // R2
    AST_ALU_NO_SRC: assert property (@(posedge clk) disable iff (rst)
        alu_en |-> (mv_en && mv_src == 5'd0)); // R4
    AST_STKBIT_WITH_OP: assert property (@(posedge clk) disable iff (rst)
        stk_bit |-> (stk_op != 2'd0)); // R9
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halted |-> !(pc_wr || mv_en || irq_entry || stk_op != 2'd0)); // R10
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (halted && !wake) |=> halted); // R10
    AST_OSC_ONLY_HALTED: assert property (@(posedge clk) disable iff (rst)
        osc_stop |-> halted); // R10
    AST_WAKE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (halted && wake) |=> (!halted && !osc_stop)); // R11

endmodule

bind useq_top useq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wake      (wake),
    .halted    (halted),
    .osc_stop  (osc_stop),
    .pc_wr     (pc_wr),
    .mv_en     (mv_en),
    .alu_en    (alu_en),
    .mv_src    (mv_src),
    .irq_entry (irq_entry),
    .stk_op    (stk_op),
    .stk_bit   (stk_bit)
);

// File: tb/sim_useq_top.sv
module sim_useq_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 64;
    localparam int STEPS = 700;

    function automatic logic [15:0] word_at(input int a);
        logic [5:0] b;
        b = a[5:0];
        if (a == 0)  return {3'b001, 5'd1, 5'd2, 3'd3};
        if (a == 63) return {3'b100, 3'b000, 10'd0};
        case (b[3:0])
            4'd0:  return 16'h0000;
            4'd1:  return {3'b001, b[4:0] ^ 5'h15, b[5:1], b[2:0]};
            4'd2:  return {3'b010, 1'b0, b[5:2], b[4:0], b[2:0]};
            4'd3:  return {3'b010, 1'b1, b[3:0], 5'd9, 3'd1};
            4'd4:  return {3'b011, 13'd0};
            4'd5:  return {3'b011, 1'b1, 12'd0};
            4'd6:  return {3'b011, 7'd0, b};
            4'd7:  return {3'b100, 1'b1, b[4], b[5], 4'd0, 6'(b + 6'd7)};
            4'd8:  return {3'b101, b[5:4], 10'd0, b[4]};
            4'd9:  return {3'b110, 13'd0};
            4'd10: return {3'b110, 7'd0, b};
            4'd11: return {3'b111, 12'd0, b[4]};
            4'd12: return {3'b111, 7'd0, b[5:1], 1'b0};
            4'd13: return {3'b100, 3'b000, 4'd0, 6'(b + 6'd2)};
            4'd14: return {3'b100, 3'b011, 4'd0, 6'(b + 6'd2)};
            default: return {3'b001, 5'd31, 5'd0, 3'd7};
        endcase
    endfunction

    function automatic logic [DEPTH*16-1:0] build_image();
        logic [DEPTH*16-1:0] r;
        r = '0;
        for (int i = 0; i < DEPTH; i++) r[i*16 +: 16] = word_at(i);
        return r;
    endfunction

    localparam logic [DEPTH*16-1:0] IMG = build_image();

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wake = 1'b0;
    logic       flag_z = 1'b0;
    logic       flag_c = 1'b0;
    logic       pc_wr;
    logic [1:0] pc_src;
    logic       mv_en;
    logic [4:0] mv_src;
    logic [4:0] mv_dst;
    logic [2:0] mv_inc;
    logic       alu_en;
    logic [3:0] alu_op;
    logic       irq_entry;
    logic [1:0] stk_op;
    logic       stk_bit;
    logic       halted;
    logic       osc_stop;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    useq_top #(
        .ROM_DEPTH (DEPTH),
        .ROM_IMAGE (IMG)
    ) u0 (
        .clk (clk), .rst (rst), .wake (wake), .flag_z (flag_z), .flag_c (flag_c),
        .pc_wr (pc_wr), .pc_src (pc_src), .mv_en (mv_en), .mv_src (mv_src),
        .mv_dst (mv_dst), .mv_inc (mv_inc), .alu_en (alu_en), .alu_op (alu_op),
        .irq_entry (irq_entry), .stk_op (stk_op), .stk_bit (stk_bit),
        .halted (halted), .osc_stop (osc_stop)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic quiet(input string tag);
        chk(tag, "pc_wr", int'(pc_wr), 0);
        chk(tag, "mv_en", int'(mv_en), 0);
        chk(tag, "irq_entry", int'(irq_entry), 0);
        chk(tag, "stk_op", int'(stk_op), 0);
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        logic [9:0]  mu;
        lf = 16'hACE1;
        mu = 10'd0;
        repeat (3) @(negedge clk);
        // R1: held in reset
        chk("R1", "halted in reset", int'(halted), 0);
        chk("R1", "osc_stop in reset", int'(osc_stop), 0);
        quiet("R1");
        rst = 1'b0;
        // R1: first fetch half after reset is address 0 (a move 1->2, inc 3)
        chk("R1", "pc_wr first fetch", int'(pc_wr), 0);

        for (int s = 0; s < STEPS; s++) begin
            logic [15:0] w;
            logic [2:0]  op;
            int e_pcs, e_src, e_dst, e_inc, e_aop, e_stk;
            bit e_mv, e_alu, e_irq, e_sb, e_halt, e_osc, taken, fsel;
            string tg;

            w  = (int'(mu) < DEPTH) ? word_at(int'(mu)) : 16'h0000;
            op = w[15:13];
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            flag_z = lf[0];
            flag_c = lf[3];
            wake   = lf[7];   // R11: ignored while running

            // expected fetch-half PC load (R7)
            e_pcs = 0;
            if (op == 3'b011 && w[12:0] == 13'd0) e_pcs = 1;
            if (op == 3'b101 && w[12:11] == 2'b00 && w[10:1] == 10'd0) e_pcs = 2;
            if (op == 3'b110 && w[12:0] == 13'd0) e_pcs = 3;

            // expected execute-half outputs
            e_mv = 0; e_alu = 0; e_src = 0; e_dst = 0; e_inc = 0; e_aop = 0;
            e_irq = 0; e_stk = 0; e_sb = 0; e_halt = 0; e_osc = 0;
            case (op)
                3'b001: begin e_mv = 1; e_src = int'(w[12:8]); e_dst = int'(w[7:3]); e_inc = int'(w[2:0]); end
                3'b010: if (!w[12]) begin
                            e_mv = 1; e_alu = 1; e_aop = int'(w[11:8]);
                            e_dst = int'(w[7:3]); e_inc = int'(w[2:0]);
                        end
                3'b011: e_irq = w[12] && (w[11:0] == 12'd0);
                3'b101: if (w[10:1] == 10'd0 && w[12:11] != 2'b11) begin
                            e_stk = int'(w[12:11]) + 1; e_sb = w[0];
                        end
                3'b111: if (w[12:1] == 12'd0) begin e_halt = 1; e_osc = w[0]; end
                default: ;
            endcase

            case (op)
                3'b000: tg = (w == 16'h0000) ? "R13" : "R12";
                3'b001: tg = "R3";
                3'b010: tg = w[12] ? "R12" : "R4";
                3'b011: tg = (e_pcs != 0) ? "R7" : (e_irq ? "R8" : "R12");
                3'b100: tg = w[12] ? "R6" : "R5";
                3'b101: tg = (e_stk != 0) ? "R9" : "R12";
                3'b110: tg = (e_pcs != 0) ? "R7" : "R12";
                default: tg = e_halt ? "R10" : "R12";
            endcase

            // fetch half (R2, R7)
            chk((e_pcs != 0) ? "R7" : "R2", "pc_wr fetch", int'(pc_wr), (e_pcs != 0) ? 1 : 0);
            chk("R7", "pc_src fetch", int'(pc_src), e_pcs);
            chk("R2", "mv_en in fetch", int'(mv_en), 0);
            chk("R2", "irq in fetch", int'(irq_entry), 0);

            @(negedge clk);
            // execute half
            chk("R2", "pc_wr in exec", int'(pc_wr), 0);
            chk(tg, "mv_en", int'(mv_en), int'(e_mv));
            chk(tg, "alu_en", int'(alu_en), int'(e_alu));
            chk(tg, "mv_src", int'(mv_src), e_src);
            chk(tg, "mv_dst", int'(mv_dst), e_dst);
            chk(tg, "mv_inc", int'(mv_inc), e_inc);
            chk(tg, "alu_op", int'(alu_op), e_aop);
            chk(tg, "irq_entry", int'(irq_entry), int'(e_irq));
            chk(tg, "stk_op", int'(stk_op), e_stk);
            chk(tg, "stk_bit", int'(stk_bit), int'(e_sb));
            chk("R10", "halted in exec", int'(halted), 0);

            // next microaddress (R5, R6, R12, R13)
            fsel  = w[11] ? flag_c : flag_z;
            taken = (op == 3'b100) && (!w[12] || (fsel == w[10]));
            mu    = taken ? w[9:0] : mu + 10'd1;

            @(negedge clk);
            if (e_halt) begin
                wake = 1'b0;
                chk("R10", "halted after halt", int'(halted), 1);
                chk("R10", "osc_stop", int'(osc_stop), int'(e_osc));
                for (int k = 0; k < 3; k++) begin
                    flag_z = ~flag_z;
                    @(negedge clk);
                    chk("R10", "still halted", int'(halted), 1);
                    quiet("R10");
                end
                wake = 1'b1;
                @(negedge clk);
                wake = 1'b0;
                chk("R11", "halted after wake", int'(halted), 0);
                chk("R11", "osc_stop after wake", int'(osc_stop), 0);
            end else begin
                chk(tg, "not halted", int'(halted), 0);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule